// File: doc/BRIEF.md
# Cascaded Clock-Enable Divider

This block turns one fast reference clock into three enable pulse trains for a processor branch, a system-bus branch and a peripheral-bus branch. Everything runs in the reference domain. The block makes no clock edges. Instead, each branch produces a one-cycle strobe that downstream logic uses as a clock enable. The source strobe comes from one of two inputs: a phase-locked-loop strobe, or a strobe that follows the 24 MHz crystal when the PLL is bypassed.

The processor branch can optionally drop one source strobe in every four, which gives a three-quarter rate. It then divides by a programmable integer. The bus branch divides the processor enables by its own integer. The peripheral branch always takes every second bus enable. Because the chain is cascaded, every bus enable coincides with a processor enable, and every peripheral enable coincides with a bus enable. The dividers are set through a small word-addressed register file of 32-bit words. One word of this file is the control word.

A new divider value waits for the end of the period that is running, so a period already started is never cut short. With a PLL strobe on every reference cycle, the reset settings give processor, bus and peripheral rates of 1/4, 1/8 and 1/16. With a PLL near 532 MHz these are 133, 66.5 and 33 MHz.

Top module: `clkdiv_tree`

## Requirements
- R1: After reset, the control word at byte offset 0x008 reads 0xD0030000 and every other word in range reads 0. No enable is high while no source strobe is given.
- R2: Control bit 22 set selects `xtal_stb` as the source strobe and bit 22 clear selects `pll_stb`. The strobe that is not selected has no effect on any enable.
- R3: With control bit 14 set, of every four source strobes counted from the moment the bit is set, the first three reach the processor divider and the fourth is dropped. With bit 14 clear, every source strobe reaches the divider.
- R4: `cpu_en` is high for exactly one cycle, in the same cycle as every (N+1)-th strobe reaching the processor divider, where N is control bits 31:30.
- R5: `ahb_en` is high in the same cycle as every (M+1)-th `cpu_en`, where M is control bits 29:28.
- R6: `ipg_en` is high in the same cycle as every second `ahb_en`.
- R7: A divider value that is written takes effect only after the current period of that divider ends. A write accepted in the same cycle as the period's final strobe applies from the following period.
- R8: A word access with `req_valid` high at a byte offset below 0x070 writes `req_wdata`, or returns the stored word on `rsp_rdata` in the next cycle, with `rsp_err` low.
- R9: An access at offset 0x070 or above returns 0 and raises `rsp_err` for one cycle in the next cycle. A write to such an offset changes no stored word.
- R10: With the reset control word and a PLL strobe on every cycle, `cpu_en`, `ahb_en` and `ipg_en` pulse on strobes 4k, 8k and 16k respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_stb | input | 1 | One-cycle strobe at the PLL output rate |
| xtal_stb | input | 1 | One-cycle strobe at the crystal rate |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_err | output | 1 | Out-of-range access flag, one cycle after the request |
| cpu_en | output | 1 | Processor-branch enable strobe |
| ahb_en | output | 1 | System-bus enable strobe |
| ipg_en | output | 1 | Peripheral-bus enable strobe |

## Verification
A divider rewrite can collide with the terminal strobe of the period that is running. In that case the processor divider is reloading in the same cycle as the write request. The bench provokes this by issuing the control write while the fourth source strobe of a divide-by-four period is present. It expects the enable in that cycle, then four more strobes at the old ratio, and only after that one enable per strobe. The gentler case, where the write lands mid-period, is judged the same way and must show the old ratio finishing its period.

// File: rtl/clkdiv_tree_pkg.sv
package clkdiv_tree_pkg;

    localparam int DIV_W        = 2;
    localparam int CPU_DIV_LSB  = 30;
    localparam int AHB_DIV_LSB  = 28;
    localparam int BYPASS_BIT   = 22;
    localparam int QRATE_BIT    = 14;
    localparam int CTRL_WORD    = 2;
    localparam int REG_LIMIT    = 'h70;
    localparam logic [31:0] CTRL_RST = 32'hD003_0000;

    typedef struct packed {
        logic [DIV_W-1:0] cpu_div;
        logic [DIV_W-1:0] ahb_div;
        logic             bypass;
        logic             qrate;
    } ctrl_t;

endpackage

// File: rtl/ccd_regfile.sv
module ccd_regfile
    import clkdiv_tree_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter int          LIMIT     = REG_LIMIT,
    parameter int          CTL_IDX   = CTRL_WORD,
    parameter logic [31:0] CTL_RESET = CTRL_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output ctrl_t             ctrl
);
    localparam int BYTES     = DATA_W / 8;
    localparam int WORD_SH   = $clog2(BYTES);
    localparam int NUM_WORDS = LIMIT / BYTES;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]                rdata;
        logic                             err;
    } state_t;

    state_t           st_d, st_q;
    logic             in_range;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] ctl_word;

    assign in_range = req_addr < ADDR_W'(LIMIT);
    assign idx      = req_addr[IDX_W+WORD_SH-1:WORD_SH];

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.err   = 1'b0;
        if (req_valid) begin
            if (in_range) begin
                if (req_write) begin
                    st_d.mem[idx] = req_wdata;
                end else begin
                    st_d.rdata = st_q.mem[idx];
                end
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.mem[CTL_IDX] <= CTL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_rdata    = st_q.rdata;
    assign rsp_err      = st_q.err;
    assign ctl_word     = st_q.mem[CTL_IDX];
    assign ctrl.cpu_div = ctl_word[CPU_DIV_LSB +: DIV_W];
    assign ctrl.ahb_div = ctl_word[AHB_DIV_LSB +: DIV_W];
    assign ctrl.bypass  = ctl_word[BYPASS_BIT];
    assign ctrl.qrate   = ctl_word[QRATE_BIT];

    // R9
    err_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // R9
    bad_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !in_range) |=> $stable(st_q.mem));

endmodule

// File: rtl/ccd_qswallow.sv
module ccd_qswallow #(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic stb_in,
    output logic stb_out
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   drop;

    assign drop    = mode_en && (st_q.cnt == '1);
    assign stb_out = stb_in && !drop;

    always_comb begin
        st_d = st_q;
        if (!mode_en) begin
            st_d.cnt = '0;
        end else if (stb_in) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_en) |-> (st_q.cnt == '0));

endmodule

// File: rtl/ccd_div.sv
module ccd_div #(
    parameter int               DIV_W   = 2,
    parameter logic [DIV_W-1:0] RST_DIV = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_in,
    input  logic [DIV_W-1:0] div_sel,
    output logic             stb_out
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
    } state_t;

    state_t st_d, st_q;
    logic   term;

    assign term    = stb_in && (st_q.cnt == st_q.act);
    assign stb_out = term;

    always_comb begin
        st_d = st_q;
        if (term) begin
            st_d.cnt = '0;
            st_d.act = div_sel;
        end else if (stb_in) begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.act <= RST_DIV;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.act);

    // R7
    reload_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.act) |-> $past(stb_out));

endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
    import clkdiv_tree_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_stb,
    input  logic              xtal_stb,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              cpu_en,
    output logic              ahb_en,
    output logic              ipg_en
);
    ctrl_t ctrl;
    logic  src_stb;
    logic  cpu_pre;

    ccd_regfile #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LIMIT    (REG_LIMIT),
        .CTL_IDX  (CTRL_WORD),
        .CTL_RESET(CTRL_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err),
        .ctrl     (ctrl)
    );

    assign src_stb = ctrl.bypass ? xtal_stb : pll_stb;

    ccd_qswallow #(.CNT_W(2)) u_quarter (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_en(ctrl.qrate),
        .stb_in (src_stb),
        .stb_out(cpu_pre)
    );

    ccd_div #(
        .DIV_W  (DIV_W),
        .RST_DIV(CTRL_RST[CPU_DIV_LSB +: DIV_W])
    ) u_cpu_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_in (cpu_pre),
        .div_sel(ctrl.cpu_div),
        .stb_out(cpu_en)
    );

    ccd_div #(
        .DIV_W  (DIV_W),
        .RST_DIV(CTRL_RST[AHB_DIV_LSB +: DIV_W])
    ) u_ahb_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_in (cpu_en),
        .div_sel(ctrl.ahb_div),
        .stb_out(ahb_en)
    );

    ccd_div #(
        .DIV_W  (1),
        .RST_DIV(1'b1)
    ) u_ipg_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_in (ahb_en),
        .div_sel(1'b1),
        .stb_out(ipg_en)
    );

    // R2
    src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.bypass ? !xtal_stb : !pll_stb) |-> !cpu_en);

    // R5
    ahb_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ahb_en |-> cpu_en);

    // R6
    ipg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipg_en |-> (ahb_en && cpu_en));

endmodule

// File: tb/clkdiv_tree_bench.sv
`timescale 1ns/1ps
module clkdiv_tree_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pll_stb = 1'b0;
    logic        xtal_stb = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        cpu_en, ahb_en, ipg_en;

    int n_chk = 0;
    int n_bad = 0;
    logic s_cpu, s_ahb, s_ipg;
    logic [31:0] b_rdata;
    logic b_err;

    always #10 clk = ~clk;

    clkdiv_tree u_clkdiv_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .pll_stb  (pll_stb),
        .xtal_stb (xtal_stb),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err),
        .cpu_en   (cpu_en),
        .ahb_en   (ahb_en),
        .ipg_en   (ipg_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pll_stb = 1'b0; xtal_stb = 1'b0; req_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic cyc(input logic p, input logic x);
        @(posedge clk);
        #1 pll_stb = p; xtal_stb = x;
        #10 s_cpu = cpu_en; s_ahb = ahb_en; s_ipg = ipg_en;
    endtask

    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic p, input logic x);
        @(posedge clk);
        #1 req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        pll_stb = p; xtal_stb = x;
        #10 s_cpu = cpu_en; s_ahb = ahb_en; s_ipg = ipg_en;
        @(posedge clk);
        #1 req_valid = 1'b0; pll_stb = 1'b0; xtal_stb = 1'b0;
        #10 b_rdata = rsp_rdata; b_err = rsp_err;
    endtask

    task automatic flush();
        logic seen = 1'b0;
        for (int i = 0; i < 64 && !seen; i++) begin
            cyc(1'b1, 1'b1);
            seen = s_ipg;
        end
        cyc(1'b0, 1'b0);
        check("flush ipg_en seen", {31'b0, seen}, 32'd1);
    endtask

    task automatic t_reset();
        do_reset();
        cyc(1'b0, 1'b0);
        check("R1 cpu_en idle", {31'b0, s_cpu}, 0);
        check("R1 ahb_en idle", {31'b0, s_ahb}, 0);
        check("R1 ipg_en idle", {31'b0, s_ipg}, 0);
        bus(1'b0, 12'h008, '0, 1'b0, 1'b0);
        check("R1 ctrl reset", b_rdata, 32'hD003_0000);
        bus(1'b0, 12'h000, '0, 1'b0, 1'b0);
        check("R1 word0 reset", b_rdata, 32'h0);
        check("R1 err low", {31'b0, b_err}, 0);
    endtask

    task automatic t_default();
        do_reset();
        for (int k = 1; k <= 32; k++) begin
            cyc(1'b1, 1'b0);
            check("R10 cpu_en", {31'b0, s_cpu}, {31'b0, k % 4 == 0});
            check("R10 ahb_en", {31'b0, s_ahb}, {31'b0, k % 8 == 0});
            check("R10 ipg_en", {31'b0, s_ipg}, {31'b0, k % 16 == 0});
        end
    endtask

    task automatic t_source();
        do_reset();
        bus(1'b1, 12'h008, 32'h0000_0000, 1'b0, 1'b0);
        flush();
        bus(1'b1, 12'h008, 32'h0040_0000, 1'b0, 1'b0);
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b1, 1'b0);
            check("R2 pll ignored in bypass", {31'b0, s_cpu}, 0);
        end
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b0, 1'b1);
            check("R2 xtal cpu_en", {31'b0, s_cpu}, 1);
            check("R2 xtal ahb_en", {31'b0, s_ahb}, 1);
            check("R6 xtal ipg_en", {31'b0, s_ipg}, {31'b0, k % 2 == 0});
        end
        bus(1'b1, 12'h008, 32'h0000_0000, 1'b0, 1'b0);
        for (int k = 1; k <= 3; k++) begin
            cyc(1'b0, 1'b1);
            check("R2 xtal ignored without bypass", {31'b0, s_cpu}, 0);
        end
        for (int k = 1; k <= 2; k++) begin
            cyc(1'b1, 1'b0);
            check("R2 pll cpu_en", {31'b0, s_cpu}, 1);
            check("R6 pll ipg_en", {31'b0, s_ipg}, {31'b0, k == 2});
        end
    endtask

    task automatic t_quarter();
        int m = 0;
        do_reset();
        bus(1'b1, 12'h008, 32'h0000_0000, 1'b0, 1'b0);
        flush();
        bus(1'b1, 12'h008, 32'h0000_4000, 1'b0, 1'b0);
        for (int k = 1; k <= 12; k++) begin
            logic pass = (k % 4) != 0;
            cyc(1'b1, 1'b0);
            if (pass) m++;
            check("R3 cpu_en swallow", {31'b0, s_cpu}, {31'b0, pass});
            check("R5 ahb_en swallow", {31'b0, s_ahb}, {31'b0, pass});
            check("R6 ipg_en swallow", {31'b0, s_ipg}, {31'b0, pass && (m % 2 == 0)});
        end
        bus(1'b1, 12'h008, 32'h0000_0000, 1'b0, 1'b0);
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b1, 1'b0);
            check("R3 mode off passes all", {31'b0, s_cpu}, 1);
        end
    endtask

    task automatic t_divide();
        int k = 0;
        do_reset();
        bus(1'b1, 12'h008, 32'hA000_0000, 1'b0, 1'b0);
        flush();
        for (int j = 0; j < 72; j++) begin
            logic st = (j % 2) == 0;
            cyc(st, 1'b0);
            if (st) k++;
            check("R4 cpu_en div3", {31'b0, s_cpu}, {31'b0, st && (k % 3 == 0)});
            check("R5 ahb_en div3", {31'b0, s_ahb}, {31'b0, st && (k % 9 == 0)});
            check("R6 ipg_en div2", {31'b0, s_ipg}, {31'b0, st && (k % 18 == 0)});
        end
    endtask

    task automatic t_change();
        do_reset();
        bus(1'b1, 12'h008, 32'hC000_0000, 1'b0, 1'b0);
        flush();
        for (int k = 1; k <= 2; k++) begin
            cyc(1'b1, 1'b0);
            check("R7 old period", {31'b0, s_cpu}, 0);
        end
        bus(1'b1, 12'h008, 32'h0000_0000, 1'b0, 1'b0);
        for (int k = 3; k <= 6; k++) begin
            cyc(1'b1, 1'b0);
            check("R7 mid-period change", {31'b0, s_cpu}, {31'b0, k >= 4});
        end
    endtask

    task automatic t_collide();
        do_reset();
        bus(1'b1, 12'h008, 32'hC000_0000, 1'b0, 1'b0);
        flush();
        for (int k = 1; k <= 3; k++) begin
            cyc(1'b1, 1'b0);
            check("R7 collide lead-in", {31'b0, s_cpu}, 0);
        end
        bus(1'b1, 12'h008, 32'h0000_0000, 1'b1, 1'b0);
        check("R7 terminal with write", {31'b0, s_cpu}, 1);
        for (int k = 5; k <= 9; k++) begin
            cyc(1'b1, 1'b0);
            check("R7 write at terminal", {31'b0, s_cpu}, {31'b0, k >= 8});
        end
    endtask

    task automatic t_bus();
        do_reset();
        bus(1'b1, 12'h06C, 32'h1234_5678, 1'b0, 1'b0);
        check("R8 write err", {31'b0, b_err}, 0);
        bus(1'b0, 12'h06C, '0, 1'b0, 1'b0);
        check("R8 readback", b_rdata, 32'h1234_5678);
        check("R8 read err", {31'b0, b_err}, 0);
        bus(1'b1, 12'h070, 32'hFFFF_FFFF, 1'b0, 1'b0);
        check("R9 bad write err", {31'b0, b_err}, 1);
        bus(1'b0, 12'h070, '0, 1'b0, 1'b0);
        check("R9 bad read data", b_rdata, 32'h0);
        check("R9 bad read err", {31'b0, b_err}, 1);
        bus(1'b0, 12'h000, '0, 1'b0, 1'b0);
        check("R9 word0 untouched", b_rdata, 32'h0);
        bus(1'b0, 12'h008, '0, 1'b0, 1'b0);
        check("R9 ctrl untouched", b_rdata, 32'hD003_0000);
        bus(1'b0, 12'hFFC, '0, 1'b0, 1'b0);
        check("R9 top of window err", {31'b0, b_err}, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_default();
        t_source();
        t_quarter();
        t_divide();
        t_change();
        t_collide();
        t_bus();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule